// File: doc/BRIEF.md
# Local Buffer Memory Bus Master Cycle Sequencer

This block runs single memory read or write cycles against an external buffer memory, acting as bus master on a 16-bit multiplexed address/data bus. A requester presents an address, a direction and (for writes) a data word. The block then steps through a fixed cycle of four bus-clock phases: an address phase, two strobe phases and a closing phase. While the ready input is held high it inserts wait phases. When the transfer ends it pulses `done` and returns read data.

In byte mode only the low lane carries data, and the high lane keeps carrying the upper address byte through the data phases. In word mode both lanes carry data. In wide-address mode an extra phase comes before the address phase: the configured upper 16 address bits are placed on the bus and a second address strobe latches them. Bus arbitration lies outside the block. Its drivers are released (all output enables low) whenever the bus grant input is low, and a request is taken only while the grant is held.

Top module: `dma_master_seq`

## Requirements
- R1: After reset the block is idle: `busy` and `done` are 0, `mwr_n` and `mrd_n` are 1, `ads0` and `ads1` are 0, and `ad_oe` is 2'b00.
- R2: While `bus_grant` is 0, `ad_oe` is 2'b00, `strobe_oe` and `ads1_oe` are 0, and a request on `req_valid` is not taken (`busy` stays 0). `ads1_oe` is 1 only when `bus_grant` and `cfg_wide` are both 1.
- R3: A request is taken on the clock edge where `req_valid`, `bus_grant` and idle all hold. The next cycle is the address phase (or the upper-address phase in wide mode). With `ready` low, the address phase, two strobe phases and the closing phase last one cycle each, and the cycle after the closing phase is idle again.
- R4: In the address phase, `ad_o` equals the request address, `ad_oe` is 2'b11, and `ads0` is 1. `ads0` is 0 in every other phase.
- R5: For a word-mode write (`cfg_word`=1), `ad_o` equals the write data with `ad_oe`=2'b11 from the first strobe phase through the closing phase.
- R6: In byte mode (`cfg_word`=0), `ad_o[15:8]` carries address bits 15:8 with lane enable `ad_oe[1]`=1 from the first strobe phase through the closing phase, for both reads and writes. For a write, `ad_o[7:0]` carries write data bits 7:0 with `ad_oe[0]`=1.
- R7: `ready` is sampled at the end of the second strobe phase. While it is 1, one wait phase follows, and a further wait phase follows each wait phase that ends with `ready` at 1. The closing phase comes after the first phase that ends with `ready` at 0.
- R8: For a write, `mwr_n` is 0 during both strobe phases and all wait phases. It returns to 1 in the closing phase while the data lanes are still driven. `mrd_n` stays 1.
- R9: For a read, `mrd_n` is 0 during both strobe phases and all wait phases, and 1 in the closing phase. The data lanes are not driven from the first strobe phase onward (`ad_oe`=2'b00 in word mode, 2'b10 in byte mode). `ad_i` is captured at the edge that ends the last strobe or wait phase. `mwr_n` stays 1.
- R10: `done` is 1 for exactly the one cycle of the closing phase. During that cycle `rd_data` holds the captured value: all 16 bits in word mode, or {8'h00, captured[7:0]} in byte mode.
- R11: In wide mode (`cfg_wide`=1), a single upper-address phase comes before the address phase. In it, `ad_o` equals `upper_addr`, `ad_oe` is 2'b11, `ads1` is 1, and both strobes are 1. `ads1` is 0 in every other phase.
- R12: A request presented while `busy` is 1 is ignored. The transfer under way keeps its own address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_grant | input | 1 | Bus acknowledge; enables all drivers |
| cfg_word | input | 1 | 1 = word transfers, 0 = byte transfers |
| cfg_wide | input | 1 | 1 = emit upper-address phase and strobe |
| upper_addr | input | 16 | Fixed upper address bits 31:16 |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Transfer address bits 15:0 |
| req_wdata | input | 16 | Write data |
| ready | input | 1 | High inserts wait phases |
| ad_i | input | 16 | Bus value seen on the shared lines |
| busy | output | 1 | Transfer under way |
| done | output | 1 | Closing-phase pulse |
| rd_data | output | 16 | Read result |
| ad_o | output | 16 | Bus value driven |
| ad_oe | output | 2 | Per-byte-lane drive enable (bit 1 = high lane) |
| ads0 | output | 1 | Lower address strobe |
| ads1 | output | 1 | Upper address strobe |
| ads1_oe | output | 1 | Drive enable for `ads1` |
| strobe_oe | output | 1 | Drive enable for `ads0`, `mwr_n`, `mrd_n` |
| mwr_n | output | 1 | Active-low write strobe |
| mrd_n | output | 1 | Active-low read strobe |

## Verification
The bench sweeps every combination of word/byte, read/write, plain/wide addressing and zero to three wait phases, using a distinct address and data word for each. It checks the bus value, the lane enables and the strobes in each phase. The sweep separates the two lane layouts and the direction-dependent lane release. It also shows that wait phases stretch only the strobe window and leave the address and closing phases unchanged. For reads, the bench presents a wrong value on `ad_i` until the last strobe or wait phase, which catches a capture taken at the wrong edge. Separate runs hold a new request during a transfer and offer a request with the grant withdrawn.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int BUS_W  = 16;
    localparam int LANE_W = 8;
    localparam int N_LANE = BUS_W / LANE_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_UADDR,
        PH_ADDR,
        PH_STB1,
        PH_STB2,
        PH_WAIT,
        PH_CLOSE
    } phase_e;

    typedef struct packed {
        logic             write;
        logic             word;
        logic [BUS_W-1:0] addr;
        logic [BUS_W-1:0] wdata;
    } xfer_s;

    function automatic logic strobe_phase(phase_e p);
        return (p == PH_STB1) || (p == PH_STB2) || (p == PH_WAIT);
    endfunction

    function automatic logic data_phase(phase_e p);
        return strobe_phase(p) || (p == PH_CLOSE);
    endfunction

    function automatic logic [BUS_W-1:0] narrow_read(logic word, logic [BUS_W-1:0] v);
        return word ? v : {{(BUS_W-LANE_W){1'b0}}, v[LANE_W-1:0]};
    endfunction

endpackage

// File: rtl/dma_phase_ctrl.sv
module dma_phase_ctrl
    import dma_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   wide,
    input  logic   ready,
    output phase_e phase
);

    phase_e phase_d;

    always_comb begin
        phase_d = phase;
        case (phase)
            PH_IDLE:  if (start) phase_d = wide ? PH_UADDR : PH_ADDR;
            PH_UADDR: phase_d = PH_ADDR;
            PH_ADDR:  phase_d = PH_STB1;
            PH_STB1:  phase_d = PH_STB2;
            PH_STB2,
            PH_WAIT:  phase_d = ready ? PH_WAIT : PH_CLOSE;
            PH_CLOSE: phase_d = PH_IDLE;
            default:  phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= phase_d;
    end

    AST_WAIT_INSERT: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_STB2 || phase == PH_WAIT) && ready) |=> (phase == PH_WAIT)); // R7
    AST_WAIT_LEAVE: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_STB2 || phase == PH_WAIT) && !ready) |=> (phase == PH_CLOSE)); // R7
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ADDR) |=> (phase == PH_STB1)); // R3

endmodule

// File: rtl/dma_bus_drive.sv
module dma_bus_drive
    import dma_seq_pkg::*;
(
    input  phase_e           phase,
    input  xfer_s            xfer,
    input  logic [BUS_W-1:0] upper_addr,
    input  logic             grant,
    input  logic             wide,
    output logic [BUS_W-1:0] ad_o,
    output logic [N_LANE-1:0] ad_oe,
    output logic             ads0,
    output logic             ads1,
    output logic             ads1_oe,
    output logic             strobe_oe,
    output logic             mwr_n,
    output logic             mrd_n
);

    logic [BUS_W-1:0]  val;
    logic [N_LANE-1:0] lanes;

    always_comb begin
        val   = '0;
        lanes = '0;
        if (phase == PH_UADDR) begin
            val   = upper_addr;
            lanes = '1;
        end else if (phase == PH_ADDR) begin
            val   = xfer.addr;
            lanes = '1;
        end else if (data_phase(phase)) begin
            if (xfer.word) begin
                val   = xfer.wdata;
                lanes = xfer.write ? '1 : '0;
            end else begin
                val   = {xfer.addr[BUS_W-1:LANE_W], xfer.wdata[LANE_W-1:0]};
                lanes = {1'b1, xfer.write};
            end
        end
    end

    assign ad_o      = val;
    assign ad_oe     = grant ? lanes : '0;
    assign ads0      = (phase == PH_ADDR);
    assign ads1      = (phase == PH_UADDR);
    assign ads1_oe   = grant && wide;
    assign strobe_oe = grant;
    assign mwr_n     = !(strobe_phase(phase) && xfer.write);
    assign mrd_n     = !(strobe_phase(phase) && !xfer.write);

endmodule

// File: rtl/dma_read_capture.sv
module dma_read_capture
    import dma_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  phase_e           phase,
    input  logic             ready,
    input  logic             is_write,
    input  logic             word,
    input  logic [BUS_W-1:0] ad_i,
    output logic [BUS_W-1:0] rd_data
);

    logic take;
    assign take = (phase == PH_STB2 || phase == PH_WAIT) && !ready && !is_write;

    always_ff @(posedge clk) begin
        if (rst)       rd_data <= '0;
        else if (take) rd_data <= narrow_read(word, ad_i);
    end

    AST_HOLD_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CLOSE) |=> $stable(rd_data)); // R10

endmodule

// File: rtl/dma_master_seq.sv
module dma_master_seq
    import dma_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_grant,
    input  logic        cfg_word,
    input  logic        cfg_wide,
    input  logic [15:0] upper_addr,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    input  logic        ready,
    input  logic [15:0] ad_i,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic [15:0] ad_o,
    output logic [1:0]  ad_oe,
    output logic        ads0,
    output logic        ads1,
    output logic        ads1_oe,
    output logic        strobe_oe,
    output logic        mwr_n,
    output logic        mrd_n
);

    phase_e phase;
    xfer_s  xfer_q;
    logic   start;

    assign start = req_valid && bus_grant && (phase == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_q <= '0;
        end else if (start) begin
            xfer_q.write <= req_write;
            xfer_q.word  <= cfg_word;
            xfer_q.addr  <= req_addr;
            xfer_q.wdata <= req_wdata;
        end
    end

    dma_phase_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .wide  (cfg_wide),
        .ready (ready),
        .phase (phase)
    );

    dma_bus_drive u_drive (
        .phase      (phase),
        .xfer       (xfer_q),
        .upper_addr (upper_addr),
        .grant      (bus_grant),
        .wide       (cfg_wide),
        .ad_o       (ad_o),
        .ad_oe      (ad_oe),
        .ads0       (ads0),
        .ads1       (ads1),
        .ads1_oe    (ads1_oe),
        .strobe_oe  (strobe_oe),
        .mwr_n      (mwr_n),
        .mrd_n      (mrd_n)
    );

    dma_read_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .ready    (ready),
        .is_write (xfer_q.write),
        .word     (xfer_q.word),
        .ad_i     (ad_i),
        .rd_data  (rd_data)
    );

    assign busy = (phase != PH_IDLE);
    assign done = (phase == PH_CLOSE);

    AST_FLOAT_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        !bus_grant |-> (ad_oe == 2'b00 && !strobe_oe && !ads1_oe)); // R2
    AST_ADS0_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ads0 |=> !ads0); // R4
    AST_ADS1_LEADS: assert property (@(posedge clk) disable iff (rst)
        ads1 |=> ads0); // R11
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_WR_RISE_DATA: assert property (@(posedge clk) disable iff (rst)
        ($rose(mwr_n) && bus_grant) |-> (ad_oe == 2'b11)); // R8
    AST_RD_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!mrd_n && bus_grant) |-> !ad_oe[0]); // R9
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        (mwr_n || mrd_n)); // R8
    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy); // R12

endmodule

// File: tb/dma_master_seq_tb.sv
module dma_master_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_grant, cfg_word, cfg_wide, req_valid, req_write, ready;
    logic [15:0] upper_addr, req_addr, req_wdata, ad_i;
    logic        busy, done, ads0, ads1, ads1_oe, strobe_oe, mwr_n, mrd_n;
    logic [15:0] rd_data, ad_o;
    logic [1:0]  ad_oe;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_master_seq u_dut (
        .clk(clk), .rst(rst), .bus_grant(bus_grant), .cfg_word(cfg_word),
        .cfg_wide(cfg_wide), .upper_addr(upper_addr), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .ready(ready), .ad_i(ad_i), .busy(busy), .done(done), .rd_data(rd_data),
        .ad_o(ad_o), .ad_oe(ad_oe), .ads0(ads0), .ads1(ads1), .ads1_oe(ads1_oe),
        .strobe_oe(strobe_oe), .mwr_n(mwr_n), .mrd_n(mrd_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    // check data lanes against the expected enable and value
    task automatic chk_lanes(input string tag, input logic [1:0] eoe, input logic [15:0] ev);
        logic [15:0] m;
        m = {{8{eoe[1]}}, {8{eoe[0]}}};
        chk(ad_oe == eoe, {tag, " oe"}, {30'd0, ad_oe}, {30'd0, eoe});
        chk((ad_o & m) == (ev & m), {tag, " ad"}, {16'd0, ad_o & m}, {16'd0, ev & m});
    endtask

    task automatic xfer(input bit word, input bit wr, input bit wide, input int nwait,
                        input logic [15:0] a, input logic [15:0] d, input logic [15:0] rv,
                        input logic [15:0] up, input bit hold_req);
        logic [1:0]  doe;
        logic [15:0] dv;
        logic [15:0] erd;
        if (wr) begin
            doe = 2'b11;
            dv  = word ? d : {a[15:8], d[7:0]};
        end else begin
            doe = word ? 2'b00 : 2'b10;
            dv  = {a[15:8], 8'h00};
        end
        erd = word ? rv : {8'h00, rv[7:0]};
        cfg_word = word; cfg_wide = wide; upper_addr = up;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        ready = 1'b0; ad_i = ~rv;
        step;
        if (!hold_req) req_valid = 1'b0;
        chk(busy == 1'b1, "R3 busy after accept", {31'd0, busy}, 32'd1);
        if (wide) begin
            chk(ad_o == up && ad_oe == 2'b11, "R11 upper addr phase", {14'd0, ad_oe, ad_o}, {14'd0, 2'b11, up});
            chk(ads1 && !ads0 && mwr_n && mrd_n, "R11 strobes in upper phase",
                {28'd0, ads1, ads0, mwr_n, mrd_n}, 32'hB);
            chk(ads1_oe == 1'b1, "R11 ads1 enable", {31'd0, ads1_oe}, 32'd1);
            step;
        end else begin
            chk(ads1_oe == 1'b0, "R2 ads1 enable off", {31'd0, ads1_oe}, 32'd0);
        end
        chk(ad_o == a && ad_oe == 2'b11, "R4 address phase", {14'd0, ad_oe, ad_o}, {14'd0, 2'b11, a});
        chk(ads0 && !ads1 && mwr_n && mrd_n, "R4 ads0 in address phase",
            {28'd0, ads0, ads1, mwr_n, mrd_n}, 32'hB);
        if (hold_req) begin
            req_addr = ~a; req_wdata = ~d; req_write = ~wr;
        end
        step;
        chk_lanes(word ? (wr ? "R5 stb1" : "R9 stb1") : "R6 stb1", doe, dv);
        chk(mwr_n == !wr && mrd_n == wr, wr ? "R8 stb1 strobes" : "R9 stb1 strobes",
            {30'd0, mwr_n, mrd_n}, {30'd0, !wr, wr});
        chk(!ads0 && !done, "R3 stb1 no ads0/done", {30'd0, ads0, done}, 32'd0);
        step;
        if (hold_req) req_valid = 1'b0;
        chk_lanes(word ? (wr ? "R5 stb2" : "R9 stb2") : "R6 stb2", doe, dv);
        chk(mwr_n == !wr && mrd_n == wr, wr ? "R8 stb2 strobes" : "R9 stb2 strobes",
            {30'd0, mwr_n, mrd_n}, {30'd0, !wr, wr});
        ready = (nwait > 0);
        if (nwait == 0) ad_i = rv;
        for (int i = 0; i < nwait; i++) begin
            step;
            chk(mwr_n == !wr && mrd_n == wr, "R7 wait phase strobe held",
                {30'd0, mwr_n, mrd_n}, {30'd0, !wr, wr});
            chk(!done, "R7 no done in wait", {31'd0, done}, 32'd0);
            chk_lanes("R7 wait lanes", doe, dv);
            ready = (i + 1 < nwait);
            if (i + 1 == nwait) ad_i = rv;
        end
        step;
        ready = 1'b0;
        ad_i = 16'h5AA5 ^ rv;
        chk(done == 1'b1, "R10 done in closing phase", {31'd0, done}, 32'd1);
        chk(mwr_n && mrd_n, wr ? "R8 closing strobes high" : "R9 closing strobes high",
            {30'd0, mwr_n, mrd_n}, 32'd3);
        chk_lanes(wr ? "R8 data held at close" : "R9 lanes at close", doe, dv);
        if (!wr) chk(rd_data == erd, "R10 read data", {16'd0, rd_data}, {16'd0, erd});
        step;
        chk(!busy && !done, "R3 idle after close", {30'd0, busy, done}, 32'd0);
        chk(ad_oe == 2'b00 && mwr_n && mrd_n && !ads0 && !ads1, "R3 idle bus",
            {25'd0, ad_oe, mwr_n, mrd_n, ads0, ads1, 1'b0}, {25'd0, 2'b00, 1'b1, 1'b1, 3'b000});
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                fails++;
                vectors++;
                $display("FAIL watchdog expired act=%0d exp<=%0d", cycles, WATCHDOG);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
                $finish;
            end
        end
    end

    initial begin : main
        rst = 1'b1; bus_grant = 1'b1; cfg_word = 1'b1; cfg_wide = 1'b0;
        upper_addr = '0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_wdata = '0; ready = 1'b0; ad_i = '0;
        @(negedge clk); step; step;
        rst = 1'b0;
        step;
        chk(!busy && !done, "R1 reset idle", {30'd0, busy, done}, 32'd0);
        chk(mwr_n && mrd_n && !ads0 && !ads1, "R1 reset strobes",
            {28'd0, mwr_n, mrd_n, ads0, ads1}, 32'hC);
        chk(ad_oe == 2'b00, "R1 reset lanes", {30'd0, ad_oe}, 32'd0);

        // no grant: drivers released and request not taken
        bus_grant = 1'b0; cfg_wide = 1'b1; req_valid = 1'b1; req_addr = 16'h1234;
        step;
        chk(!busy, "R2 request refused without grant", {31'd0, busy}, 32'd0);
        chk(ad_oe == 2'b00 && !strobe_oe && !ads1_oe, "R2 outputs released",
            {29'd0, ad_oe, strobe_oe | ads1_oe}, 32'd0);
        step;
        chk(!busy, "R2 still idle", {31'd0, busy}, 32'd0);
        req_valid = 1'b0; bus_grant = 1'b1;
        step;
        chk(strobe_oe && ads1_oe, "R2 enables with grant", {30'd0, strobe_oe, ads1_oe}, 32'd3);

        // sweep: lane layout x direction x address width x wait count
        for (int idx = 0; idx < 32; idx++) begin
            logic [15:0] a, d;
            a = 16'(idx * 16'h1357) ^ 16'hA5C3;
            d = 16'(idx * 16'h0F1D) + 16'h2468;
            xfer(idx[4], idx[3], idx[2], idx % 4, a, d, ~d ^ 16'h0C30,
                 16'hBEE0 + 16'(idx), 1'b0);
        end

        // new request held while busy must not disturb the running transfer
        xfer(1'b0, 1'b1, 1'b0, 1, 16'hC3A1, 16'h7E42, 16'h0000, 16'h0000, 1'b1); // R12
        xfer(1'b1, 1'b0, 1'b1, 2, 16'h4D2B, 16'h0000, 16'h9F17, 16'h8001, 1'b1); // R12
        chk(!busy, "R12 no extra transfer", {31'd0, busy}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule